// File: doc/BRIEF.md
# Serial Status Flags with Write-Zero Clear

This block keeps the status flags of a FIFO-based serial port and the control bits that act on them. The transmit path, the receive path and the line monitor report events on single-cycle strobes: a break was seen, the receive trigger level was reached, or received data is ready. Software works with three word addresses on a simple register bus: a control register, a transmit data register and a status register.

Software clears a status flag by writing 0 to its bit. A 1 in the written word leaves that flag as it is. Three actions set transmit flags: clearing the transmit-enable control bit, writing transmit data, and reading the status register while the transmitter is enabled. That read sets the flags again after it has returned the old value. The block drives a registered receive interrupt and a transmit interrupt that follows a control bit. The byte written to the transmit data register goes out on a load strobe to the shifter.

Address map: control at word 1, transmit data at word 2, status at word 3. Every other word is unmapped. Reads return data combinationally in the cycle that `rd_en` is high. All state changes take effect at the next rising clock edge.

Top module: `ust_status_top`

## Requirements
- R1: After reset, the status register reads 0x60 (transmit-end and transmit-empty set), the control register reads 0x20 (transmit enable set), and both interrupt outputs are 0.
- R2: The status word has transmit-end at bit 6, transmit-data-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0. Bits 7, 3 and 2 always read 0.
- R3: A status write clears every flag whose bit in the written word is 0. It leaves every flag whose bit is 1 unchanged.
- R4: A status write with bit 1 or bit 0 at 0 deasserts the receive interrupt from the next cycle on. A status write with both bits at 1 leaves the interrupt as it was.
- R5: A write to the transmit data register clears transmit-data-empty. It also presents the written byte on `tx_byte` with a one-cycle `tx_load` pulse.
- R6: A control write with bit 5 (transmit enable) at 0 sets transmit-end.
- R7: A status read returns the flags as they were before the read. If control bit 5 is 1, the read then sets transmit-end and transmit-data-empty. If control bit 5 is 0, the read changes no flag.
- R8: A control write with bit 6 (receive interrupt enable) at 0 deasserts the receive interrupt on the next cycle. `tx_irq` equals control bit 7 from the cycle after the write.
- R9: A receive-trigger event sets receive-full. If control bit 6 is 1, it also asserts `rx_irq` on the next cycle. If control bit 6 is 0, `rx_irq` stays 0.
- R10: When an event and a clearing write fall in the same cycle, the flag or interrupt that the event sets stays set.
- R11: Reads of unmapped words return 0 and change no state. Writes to unmapped words change no state.
- R12: A break event sets the break flag. A data-ready event sets the data-ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| ev_brk | input | 1 | Break detected strobe |
| ev_rx_trig | input | 1 | Receive trigger level reached strobe |
| ev_rx_ready | input | 1 | Received data ready strobe |
| tx_load | output | 1 | One-cycle pulse after a transmit data write |
| tx_byte | output | 8 | Last byte written to transmit data |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
A flag with the wrong value shows up on the first status read after the faulty edge, because reads are combinational. The read side effect shows up only on the read after that one. For this reason the bench always reads twice when it checks a re-arm. A wrong receive interrupt state is visible on `rx_irq` one cycle after the event or write that caused it. The bench applies all 256 status write values to a fully set flag word, so a mask bit mapped to the wrong flag cannot go unnoticed.

// File: rtl/ust_pkg.sv
package ust_pkg;
  localparam int DW = 8;
  // status bit positions (software decodes these)
  localparam int S_TEND = 6;
  localparam int S_TDE  = 5;
  localparam int S_BRK  = 4;
  localparam int S_RDF  = 1;
  localparam int S_DR   = 0;
  // control bit positions
  localparam int C_TXEN = 5;
  localparam int C_RIE  = 6;
  localparam int C_TIE  = 7;
  localparam logic [DW-1:0] CTRL_RESET = 8'h20;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } ust_flags_t;

  localparam ust_flags_t FLAGS_RESET = '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};

  function automatic logic [DW-1:0] pack_status(input ust_flags_t f);
    logic [DW-1:0] w;
    w = '0;
    w[S_TEND] = f.tend;
    w[S_TDE]  = f.tde;
    w[S_BRK]  = f.brk;
    w[S_RDF]  = f.rdf;
    w[S_DR]   = f.dr;
    return w;
  endfunction

  // flags that a status write with this value clears
  function automatic ust_flags_t clear_mask(input logic [DW-1:0] w);
    ust_flags_t m;
    m.tend = ~w[S_TEND];
    m.tde  = ~w[S_TDE];
    m.brk  = ~w[S_BRK];
    m.rdf  = ~w[S_RDF];
    m.dr   = ~w[S_DR];
    return m;
  endfunction

  // merge: a set always wins over a clear in the same cycle
  function automatic ust_flags_t merge_flags(input ust_flags_t cur, input ust_flags_t set,
                                             input ust_flags_t clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/ust_decode.sv
module ust_decode #(
  parameter int AW = 3,
  parameter logic [AW-1:0] A_CTRL = 3'd1,
  parameter logic [AW-1:0] A_TXD  = 3'd2,
  parameter logic [AW-1:0] A_STAT = 3'd3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_ctrl,
  output logic          wr_txd,
  output logic          wr_stat,
  output logic          rd_ctrl,
  output logic          rd_stat,
  output logic          rd_unmapped
);
  logic hit_ctrl, hit_txd, hit_stat;
  assign hit_ctrl = (addr == A_CTRL);
  assign hit_txd  = (addr == A_TXD);
  assign hit_stat = (addr == A_STAT);

  assign wr_ctrl = wr_en & hit_ctrl;
  assign wr_txd  = wr_en & hit_txd;
  assign wr_stat = wr_en & hit_stat;
  assign rd_ctrl = rd_en & hit_ctrl;
  assign rd_stat = rd_en & hit_stat;
  assign rd_unmapped = rd_en & ~hit_ctrl & ~hit_stat;

  // R11: at most one register strobe per access
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ctrl, wr_txd, wr_stat}));
endmodule

// File: rtl/ust_ctrl.sv
module ust_ctrl
  import ust_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_txd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic          txen,
  output logic          rie,
  output logic          tie,
  output logic          ctl_txen_off,
  output logic          ctl_rie_off,
  output logic          tx_load,
  output logic [DW-1:0] tx_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      tx_byte <= '0;
      tx_load <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_txd)  tx_byte <= wdata;
      tx_load <= wr_txd;
    end
  end

  assign txen = ctrl_q[C_TXEN];
  assign rie  = ctrl_q[C_RIE];
  assign tie  = ctrl_q[C_TIE];
  assign ctl_txen_off = wr_ctrl & ~wdata[C_TXEN];
  assign ctl_rie_off  = wr_ctrl & ~wdata[C_RIE];

  // R5: the byte is presented with a load pulse
  p_load_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> tx_load && tx_byte == $past(wdata));
  // R8: control value is held between writes
  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/ust_flags.sv
module ust_flags
  import ust_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic          wr_txd,
  input  logic          rd_stat,
  input  logic [DW-1:0] wdata,
  input  logic          txen,
  input  logic          ctl_txen_off,
  input  logic          ev_brk,
  input  logic          ev_rx_trig,
  input  logic          ev_rx_ready,
  output ust_flags_t    flags_q,
  output logic [DW-1:0] status_word
);
  ust_flags_t set_v, clr_v, wmask;
  logic rearm;

  assign rearm = rd_stat & txen;
  assign wmask = wr_stat ? clear_mask(wdata) : '0;

  always_comb begin
    set_v      = '0;
    set_v.tend = rearm | ctl_txen_off;
    set_v.tde  = rearm;
    set_v.brk  = ev_brk;
    set_v.rdf  = ev_rx_trig;
    set_v.dr   = ev_rx_ready;
    clr_v      = wmask;
    clr_v.tde  = wmask.tde | wr_txd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAGS_RESET;
    else        flags_q <= merge_flags(flags_q, set_v, clr_v);
  end

  assign status_word = pack_status(flags_q);

  // R2: reserved bits never set
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & 8'h8C) == 8'h00);
  // R5: transmit data write empties the holding flag
  p_txd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && !rearm) |=> !flags_q.tde);
  // R6: disabling the transmitter marks it finished
  p_txoff_tend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_txen_off |=> flags_q.tend);
  // R7: status read with transmitter on re-arms both flags
  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> flags_q.tend && flags_q.tde);
  // R10: events win over a clearing write
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_brk || ev_rx_trig) |=> (flags_q.brk || !$past(ev_brk)) && (flags_q.rdf || !$past(ev_rx_trig)));
  // R3: ones in a status write keep flags that had no other cause to change
  p_keep_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[S_BRK] && flags_q.brk) |=> flags_q.brk);
endmodule

// File: rtl/ust_irq.sv
module ust_irq
  import ust_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  input  logic          rie,
  input  logic          tie,
  input  logic          ctl_rie_off,
  input  logic          ev_rx_trig,
  output logic          rx_irq,
  output logic          tx_irq
);
  logic rx_set, rx_clr, stat_rx_clr;

  assign stat_rx_clr = wr_stat & (~wdata[S_RDF] | ~wdata[S_DR]);
  assign rx_set = ev_rx_trig & rie;
  assign rx_clr = stat_rx_clr | ctl_rie_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_irq <= 1'b0;
    else if (rx_set) rx_irq <= 1'b1;
    else if (rx_clr) rx_irq <= 1'b0;
  end

  assign tx_irq = tie;

  // R4: status write touching receive flags drops the interrupt
  p_stat_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rx_clr && !rx_set) |=> !rx_irq);
  // R8: disabling receive interrupts drops the line
  p_rie_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rie_off && !rx_set) |=> !rx_irq);
  // R9: trigger with enable raises the line
  p_trig_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> rx_irq);
  // R9: the line never rises without a trigger
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_set |=> !$rose(rx_irq));
endmodule

// File: rtl/ust_status_top.sv
module ust_status_top
  import ust_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          ev_brk,
  input  logic          ev_rx_trig,
  input  logic          ev_rx_ready,
  output logic          tx_load,
  output logic [DW-1:0] tx_byte,
  output logic          rx_irq,
  output logic          tx_irq
);
  logic wr_ctrl, wr_txd, wr_stat, rd_ctrl, rd_stat, rd_unmapped;
  logic txen, rie, tie, ctl_txen_off, ctl_rie_off;
  logic [DW-1:0] ctrl_q, status_word;
  ust_flags_t flags_q;

  ust_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_ctrl(wr_ctrl), .wr_txd(wr_txd), .wr_stat(wr_stat),
    .rd_ctrl(rd_ctrl), .rd_stat(rd_stat), .rd_unmapped(rd_unmapped)
  );

  ust_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_txd(wr_txd), .wdata(wdata),
    .ctrl_q(ctrl_q), .txen(txen), .rie(rie), .tie(tie),
    .ctl_txen_off(ctl_txen_off), .ctl_rie_off(ctl_rie_off),
    .tx_load(tx_load), .tx_byte(tx_byte)
  );

  ust_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_txd(wr_txd), .rd_stat(rd_stat),
    .wdata(wdata), .txen(txen), .ctl_txen_off(ctl_txen_off),
    .ev_brk(ev_brk), .ev_rx_trig(ev_rx_trig), .ev_rx_ready(ev_rx_ready),
    .flags_q(flags_q), .status_word(status_word)
  );

  ust_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wdata(wdata),
    .rie(rie), .tie(tie), .ctl_rie_off(ctl_rie_off), .ev_rx_trig(ev_rx_trig),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  always_comb begin
    if (rd_stat)      rd_data = status_word;
    else if (rd_ctrl) rd_data = ctrl_q;
    else              rd_data = '0;
  end

  // R11: unmapped reads return zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> rd_data == '0);
  // R11: an unmapped read with no other activity changes nothing
  p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_unmapped && !wr_en && !ev_brk && !ev_rx_trig && !ev_rx_ready)
      |=> $stable(status_word) && $stable(ctrl_q) && $stable(rx_irq));
  // R8: transmit interrupt tracks the written control bit
  p_tie_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> tx_irq == $past(wdata[C_TIE]));
endmodule

// File: tb/sim_ust_status_top.sv
`timescale 1ns/1ps
module sim_ust_status_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic ev_brk = 1'b0, ev_rx_trig = 1'b0, ev_rx_ready = 1'b0;
  logic [7:0] rd_data, tx_byte;
  logic tx_load, rx_irq, tx_irq;
  int total = 0, bad = 0;
  logic done = 1'b0;

  localparam logic [2:0] CTRL = 3'd1, TXD = 3'd2, STAT = 3'd3;

  always #2 clk = ~clk;

  ust_status_top u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rd_data(rd_data), .ev_brk(ev_brk), .ev_rx_trig(ev_rx_trig), .ev_rx_ready(ev_rx_ready),
    .tx_load(tx_load), .tx_byte(tx_byte), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic b, input logic t, input logic r);
    ev_brk = b; ev_rx_trig = t; ev_rx_ready = r;
    @(posedge clk); #1;
    ev_brk = 1'b0; ev_rx_trig = 1'b0; ev_rx_ready = 1'b0;
  endtask

  // expected status after a write of v to a fully set flag word
  function automatic logic [7:0] exp_after(input logic [7:0] v);
    return v & 8'b0111_0011;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(STAT, d); check("R1 status", d, 8'h60);
    rd(CTRL, d); check("R1 ctrl", d, 8'h20);
    check("R1 irqs", {6'b0, rx_irq, tx_irq}, 8'h00);

    // R5 transmit data write
    addr = TXD; wdata = 8'h5A; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
    check("R5 load", {7'b0, tx_load}, 8'h01);
    check("R5 byte", tx_byte, 8'h5A);
    rd(STAT, d); check("R5 tde cleared", d, 8'h40);
    // R7 re-arm visible on the following read
    rd(STAT, d); check("R7 rearm", d, 8'h60);

    // R7 no re-arm with transmitter off
    wr(CTRL, 8'h00);
    wr(STAT, 8'h00);
    rd(STAT, d); check("R3 all cleared", d, 8'h00);
    rd(STAT, d); check("R7 no rearm when off", d, 8'h00);
    // R6
    wr(CTRL, 8'h00);
    rd(STAT, d); check("R6 tend set", d, 8'h40);

    // R12 break and data ready
    pulse(1'b1, 1'b0, 1'b0);
    rd(STAT, d); check("R12 brk", d, 8'h50);
    pulse(1'b0, 1'b0, 1'b1);
    rd(STAT, d); check("R12 dr", d, 8'h51);

    // R9 trigger without enable
    pulse(1'b0, 1'b1, 1'b0);
    check("R9 no irq", {7'b0, rx_irq}, 8'h00);
    rd(STAT, d); check("R9 rdf", d, 8'h53);
    // R9 trigger with enable
    wr(CTRL, 8'h40);
    pulse(1'b0, 1'b1, 1'b0);
    check("R9 irq", {7'b0, rx_irq}, 8'h01);
    // R8 rie off drops irq; tie follows
    wr(CTRL, 8'h80);
    check("R8 rx drop", {7'b0, rx_irq}, 8'h00);
    check("R8 tie on", {7'b0, tx_irq}, 8'h01);
    wr(CTRL, 8'h00);
    check("R8 tie off", {7'b0, tx_irq}, 8'h00);

    // R10 event and clearing write in the same cycle
    wr(CTRL, 8'h40);
    addr = STAT; wdata = 8'h00; wr_en = 1'b1; ev_brk = 1'b1; ev_rx_trig = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0; ev_brk = 1'b0; ev_rx_trig = 1'b0;
    check("R10 irq kept", {7'b0, rx_irq}, 8'h01);
    rd(STAT, d); check("R10 flags kept", d, 8'h12);

    // R11 unmapped reads and writes
    for (int a = 0; a < 8; a++) begin
      if (a != CTRL && a != STAT) begin
        rd(a[2:0], d); check("R11 unmapped read", d, 8'h00);
      end
    end
    rd(STAT, d); check("R11 status stable", d, 8'h12);
    check("R11 irq stable", {7'b0, rx_irq}, 8'h01);
    wr(3'd0, 8'h00); wr(3'd7, 8'h00);
    rd(STAT, d); check("R11 write ignored", d, 8'h12);
    rd(CTRL, d); check("R11 ctrl kept", d, 8'h40);

    // R3/R4/R2 sweep over every status write value
    wr(CTRL, 8'h60);
    for (int v = 0; v < 256; v++) begin
      pulse(1'b1, 1'b1, 1'b1);
      rd(STAT, d);                 // re-arms tend/tde
      wr(STAT, v[7:0]);
      check("R4 irq after write", {7'b0, rx_irq}, {7'b0, v[1] & v[0]});
      rd(STAT, d);
      check("R3 masked clear", d, exp_after(v[7:0]));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule